// File: doc/BRIEF.md
# Deterministic Per-Core Store Buffer

This block sits beside one core and captures every store the core issues while a quantum's parallel phase runs. Nothing reaches shared memory during that phase, so cores cannot communicate. Each store targets one word, given as a word address, with a byte-enable mask. A later store to a word that is already buffered is folded into the existing entry. The core's loads probe the buffer, so the core still sees its own buffered writes.

A commit request drains the entries to a memory write port, one per cycle, in ascending entry index. Entries are allocated in the order in which words are first stored, so the same program always produces the same sequence of memory writes. A save request streams the same entries out of a context port instead of memory, which lets the runtime switch threads. The restore inputs put previously saved entries back. A store to a new word when every entry is in use raises a trap and is dropped.

Top module: `det_store_buf`

## Requirements
- R1: While no commit is in progress, an accepted store or restore never produces a memory write (`memWrValid` stays 0).
- R2: After `commitReq` is sampled high in idle, entries are written on the memory port one per cycle in ascending entry index, starting in the cycle after the request. Entry index is the order in which each word was first stored.
- R3: `commitDone` is high for exactly one cycle, in the cycle after the last write, or in the cycle after the request if the buffer was empty. The buffer is empty afterwards.
- R4: A store to a word that is already buffered updates that entry. Bytes whose enable bit (bit k selects bits 8k+7..8k) is set take the new data, and the enable mask becomes the OR of the old and new masks. No new entry is allocated.
- R5: The load port reports, combinationally, `ldHit`=1 with the entry's data and mask when `ldAddr` matches a buffered word, and `ldHit`=0 otherwise.
- R6: A store or restore to a new word when all DEPTH entries are in use drives `fullTrap` high in that cycle and is discarded. A store to an already buffered word merges without a trap even when the buffer is full.
- R7: `stReady` is 0 while a commit or save is in progress or `rstrValid` is high. A store presented with `stReady` 0 is ignored.
- R8: After `saveReq` is sampled high in idle (with `commitReq` low), entries leave on the save port one per cycle in ascending index. `saveDone` pulses once in the following cycle, the buffer ends empty, and no memory write occurs.
- R9: A restore entry is inserted exactly like a store, taking priority over a store in the same cycle. Restored entries are committed in restore order.
- R10: After reset the buffer is empty, `stReady`=1, and `memWrValid`, `saveValid`, `ldHit`, `fullTrap`, `commitDone` and `saveDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Core store request |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stBe | input | DATA_W/8 | Store byte enables |
| stReady | output | 1 | Store accepted this cycle when high |
| ldAddr | input | ADDR_W | Load lookup word address |
| ldHit | output | 1 | Lookup matched a buffered word |
| ldData | output | DATA_W | Buffered data of the match |
| ldBe | output | DATA_W/8 | Valid bytes of the match |
| commitReq | input | 1 | Start publishing the buffer |
| commitDone | output | 1 | One-cycle end of commit |
| memWrValid | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write word address |
| memWrData | output | DATA_W | Memory write data |
| memWrBe | output | DATA_W/8 | Memory write byte enables |
| saveReq | input | 1 | Start moving contents to the context area |
| saveDone | output | 1 | One-cycle end of save |
| saveValid | output | 1 | Save entry strobe |
| saveAddr | output | ADDR_W | Saved word address |
| saveData | output | DATA_W | Saved data |
| saveBe | output | DATA_W/8 | Saved byte enables |
| rstrValid | input | 1 | Restore entry strobe |
| rstrAddr | input | ADDR_W | Restored word address |
| rstrData | input | DATA_W | Restored data |
| rstrBe | input | DATA_W/8 | Restored byte enables |
| fullTrap | output | 1 | New word refused because all entries are in use |

## Verification
Commits are tried with stores to distinct words and with repeated partial-mask stores to the same word. The first case shows whether entries leave in allocation order. The second shows whether merging keeps a single entry with the newest bytes and the OR'd mask. An overfilled buffer separates a refused new word from an accepted merge, and a store held during a commit shows whether busy-time stores are dropped. A save followed by a restore in reversed order, and then a commit, shows that the drain order comes from the restore order and not from the addresses. An empty commit checks where the done pulse falls.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_SAVE   = 2'd2
  } dsbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic insertEn;    // write the selected source into the buffer
    logic useRestore;  // source is the restore port, else the store port
    logic clearAll;    // drop every entry (end of commit or save)
  } dsbStrobe_t;
endpackage

// File: rtl/dsb_datapath.sv
module dsb_datapath
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dsbStrobe_t        strobe,
  input  logic [CNT_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BE_W-1:0]   stBe,
  input  logic [ADDR_W-1:0] rstrAddr,
  input  logic [DATA_W-1:0] rstrData,
  input  logic [BE_W-1:0]   rstrBe,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic [BE_W-1:0]   ldBe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [BE_W-1:0]   rdBe,
  output logic [CNT_W-1:0]  count,
  output logic              matchAny,
  output logic              full
);
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [BE_W-1:0]   entBe   [DEPTH];

  logic [ADDR_W-1:0] inAddr;
  logic [DATA_W-1:0] inData;
  logic [BE_W-1:0]   inBe;
  logic [DATA_W-1:0] inMask;
  logic [DEPTH-1:0]  matchVec;
  logic [DEPTH-1:0]  entValid;

  assign inAddr = strobe.useRestore ? rstrAddr : stAddr;
  assign inData = strobe.useRestore ? rstrData : stData;
  assign inBe   = strobe.useRestore ? rstrBe   : stBe;
  assign full   = (count == CNT_W'(DEPTH));
  assign matchAny = |matchVec;

  // Expand byte enables to a bit mask
  genvar gb;
  generate
    for (gb = 0; gb < BE_W; gb++) begin : g_mask
      assign inMask[gb*8 +: 8] = {8{inBe[gb]}};
    end
  endgenerate

  genvar ge;
  generate
    for (ge = 0; ge < DEPTH; ge++) begin : g_ent
      assign entValid[ge] = (CNT_W'(ge) < count);
      assign matchVec[ge] = entValid[ge] && (entAddr[ge] == inAddr);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entAddr[ge] <= '0;
          entData[ge] <= '0;
          entBe[ge]   <= '0;
        end else if (strobe.insertEn && !strobe.clearAll) begin
          if (matchVec[ge]) begin
            entData[ge] <= (entData[ge] & ~inMask) | (inData & inMask);
            entBe[ge]   <= entBe[ge] | inBe;
          end else if (!matchAny && !full && (CNT_W'(ge) == count)) begin
            entAddr[ge] <= inAddr;
            entData[ge] <= inData;
            entBe[ge]   <= inBe;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clearAll) begin
      count <= '0;
    end else if (strobe.insertEn && !matchAny && !full) begin
      count <= count + 1'b1;
    end
  end

  // Load lookup: at most one entry per word, so the hits are OR'd together
  always_comb begin
    ldHit  = 1'b0;
    ldData = '0;
    ldBe   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && (entAddr[i] == ldAddr)) begin
        ldHit  = 1'b1;
        ldData = ldData | entData[i];
        ldBe   = ldBe | entBe[i];
      end
    end
  end

  always_comb begin
    rdAddr = '0;
    rdData = '0;
    rdBe   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) == rdIdx) begin
        rdAddr = entAddr[i];
        rdData = entData[i];
        rdBe   = entBe[i];
      end
    end
  end

  a_r6_trap_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.insertEn && !strobe.clearAll && full && !matchAny) |=> (count == $past(count)));
  a_r4_merge_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.insertEn && !strobe.clearAll && matchAny) |=> (count == $past(count)));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             rstrValid,
  input  logic             commitReq,
  input  logic             saveReq,
  input  logic [CNT_W-1:0] count,
  input  logic             matchAny,
  input  logic             full,
  output dsbStrobe_t       strobe,
  output logic [CNT_W-1:0] rdIdx,
  output logic             stReady,
  output logic             fullTrap,
  output logic             memWrValid,
  output logic             commitDone,
  output logic             saveValid,
  output logic             saveDone
);
  dsbState_t state;
  logic      idle;
  logic      drainEnd;

  assign idle     = (state == ST_IDLE);
  assign drainEnd = !idle && (rdIdx == count);
  assign stReady  = idle && !rstrValid;

  assign strobe.useRestore = rstrValid;
  assign strobe.insertEn   = idle && (rstrValid || stValid);
  assign strobe.clearAll   = drainEnd;

  assign fullTrap   = strobe.insertEn && !matchAny && full;
  assign memWrValid = (state == ST_COMMIT) && (rdIdx < count);
  assign saveValid  = (state == ST_SAVE) && (rdIdx < count);
  assign commitDone = (state == ST_COMMIT) && drainEnd;
  assign saveDone   = (state == ST_SAVE) && drainEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rdIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          rdIdx <= '0;
          if (commitReq)    state <= ST_COMMIT;
          else if (saveReq) state <= ST_SAVE;
        end
        default: begin
          if (drainEnd) begin
            state <= ST_IDLE;
            rdIdx <= '0;
          end else begin
            rdIdx <= rdIdx + 1'b1;
          end
        end
      endcase
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);
  a_r2_write_step: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && $past(memWrValid)) |-> (rdIdx == $past(rdIdx) + 1'b1));
  a_r8_save_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    saveValid |-> !memWrValid);
endmodule

// File: rtl/det_store_buf.sv
module det_store_buf
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [BE_W-1:0]   stBe,
  output logic              stReady,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic [BE_W-1:0]   ldBe,
  input  logic              commitReq,
  output logic              commitDone,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [BE_W-1:0]   memWrBe,
  input  logic              saveReq,
  output logic              saveDone,
  output logic              saveValid,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [DATA_W-1:0] saveData,
  output logic [BE_W-1:0]   saveBe,
  input  logic              rstrValid,
  input  logic [ADDR_W-1:0] rstrAddr,
  input  logic [DATA_W-1:0] rstrData,
  input  logic [BE_W-1:0]   rstrBe,
  output logic              fullTrap
);
  dsbStrobe_t        strobe;
  logic [CNT_W-1:0]  rdIdx;
  logic [CNT_W-1:0]  count;
  logic              matchAny;
  logic              full;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic [BE_W-1:0]   rdBe;

  dsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .rstrValid(rstrValid),
    .commitReq(commitReq), .saveReq(saveReq), .count(count),
    .matchAny(matchAny), .full(full), .strobe(strobe), .rdIdx(rdIdx),
    .stReady(stReady), .fullTrap(fullTrap), .memWrValid(memWrValid),
    .commitDone(commitDone), .saveValid(saveValid), .saveDone(saveDone)
  );

  dsb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdIdx(rdIdx),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .rstrAddr(rstrAddr), .rstrData(rstrData), .rstrBe(rstrBe),
    .ldAddr(ldAddr), .ldHit(ldHit), .ldData(ldData), .ldBe(ldBe),
    .rdAddr(rdAddr), .rdData(rdData), .rdBe(rdBe),
    .count(count), .matchAny(matchAny), .full(full)
  );

  assign memWrAddr = rdAddr;
  assign memWrData = rdData;
  assign memWrBe   = rdBe;
  assign saveAddr  = rdAddr;
  assign saveData  = rdData;
  assign saveBe    = rdBe;

  a_r1_no_write_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady) |-> !memWrValid);
  a_r3_empty_after_done: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> (count == '0));
endmodule

// File: tb/det_store_buf_tb.sv
`timescale 1ns/1ps
module det_store_buf_tb;
  localparam int AW = 16, DW = 32, DP = 4, BW = DW / 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic stValid = 0; logic [AW-1:0] stAddr = 0; logic [DW-1:0] stData = 0; logic [BW-1:0] stBe = 0;
  logic stReady, ldHit, commitReq = 0, commitDone, memWrValid, saveReq = 0, saveDone, saveValid;
  logic [AW-1:0] ldAddr = 0, memWrAddr, saveAddr;
  logic [DW-1:0] ldData, memWrData, saveData;
  logic [BW-1:0] ldBe, memWrBe, saveBe;
  logic rstrValid = 0; logic [AW-1:0] rstrAddr = 0; logic [DW-1:0] rstrData = 0; logic [BW-1:0] rstrBe = 0;
  logic fullTrap;

  always #2.5 clk = ~clk;

  det_store_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u_dut (.*);

  int tests = 0, fails = 0;
  logic [AW+DW+BW-1:0] memQ[$], saveQ[$];
  // bench model of buffer contents in entry order
  logic [AW-1:0] mA[$]; logic [DW-1:0] mD[$]; logic [BW-1:0] mB[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bmask(input logic [BW-1:0] be);
    for (int k = 0; k < BW; k++) bmask[k*8 +: 8] = {8{be[k]}};
  endfunction

  // returns 1 when the model predicts a trap
  function automatic bit modelIns(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    for (int i = 0; i < mA.size(); i++)
      if (mA[i] == a) begin
        mD[i] = (mD[i] & ~bmask(b)) | (d & bmask(b));
        mB[i] = mB[i] | b;
        return 1'b0;
      end
    if (mA.size() == DP) return 1'b1;
    mA.push_back(a); mD.push_back(d); mB.push_back(b);
    return 1'b0;
  endfunction

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    bit expTrap;
    expTrap = modelIns(a, d, b);
    @(posedge clk); #1;
    stValid = 1; stAddr = a; stData = d; stBe = b;
    @(negedge clk);
    chk(expTrap ? "R6 trap on new word when full" : "R6 no trap", 64'(fullTrap), 64'(expTrap));
    @(posedge clk); #1; stValid = 0;
  endtask

  task automatic doRestore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
    void'(modelIns(a, d, b));
    @(posedge clk); #1;
    rstrValid = 1; rstrAddr = a; rstrData = d; rstrBe = b;
    stValid = 1; stAddr = 16'h0EEE; stData = '1; stBe = '1; // must lose to the restore (R9, R7)
    @(negedge clk);
    chk("R7 stReady low under restore", 64'(stReady), 64'd0);
    @(posedge clk); #1; rstrValid = 0; stValid = 0;
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic expHit,
                       input logic [DW-1:0] expD, input logic [BW-1:0] expB);
    @(posedge clk); #1; ldAddr = a;
    @(negedge clk);
    chk(req, 64'(ldHit), 64'(expHit));
    if (expHit) begin chk(req, 64'(ldData), 64'(expD)); chk(req, 64'(ldBe), 64'(expB)); end
  endtask

  // commit (isSave=0) or save (isSave=1); checks done timing, store stall
  task automatic drain(input bit isSave);
    int n, k;
    n = mA.size();
    for (int i = 0; i < n; i++) begin
      if (isSave) saveQ.push_back({mA[i], mD[i], mB[i]});
      else        memQ.push_back({mA[i], mD[i], mB[i]});
    end
    mA.delete(); mD.delete(); mB.delete();
    @(posedge clk); #1;
    if (isSave) saveReq = 1; else commitReq = 1;
    @(posedge clk); #1;
    saveReq = 0; commitReq = 0;
    stValid = 1; stAddr = 16'h0777; stData = 32'h12345678; stBe = '1; // busy-time store
    k = 1;
    forever begin
      @(negedge clk);
      if (k == 1) chk("R7 stReady low while busy", 64'(stReady), 64'd0);
      if (isSave ? saveDone : commitDone) break;
      k++;
      if (k > 20) break;
    end
    stValid = 0;
    chk(isSave ? "R8 saveDone timing" : "R3 commitDone timing", 64'(k), 64'(n + 1));
    @(posedge clk); #1;
    @(negedge clk);
    chk("R3 single done pulse", 64'(commitDone | saveDone), 64'd0);
    chk(isSave ? "R8 queue drained" : "R2 queue drained",
        64'(isSave ? saveQ.size() : memQ.size()), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rstN) begin
    if (memWrValid) begin
      if (memQ.size() == 0) chk("R1 unexpected memory write", 64'(memWrAddr), 64'hFFFF_FFFF);
      else chk("R2 commit order/content", 64'({memWrAddr, memWrData, memWrBe}), 64'(memQ.pop_front()));
    end
    if (saveValid) begin
      if (saveQ.size() == 0) chk("R8 unexpected save entry", 64'(saveAddr), 64'hFFFF_FFFF);
      else chk("R8 save order/content", 64'({saveAddr, saveData, saveBe}), 64'(saveQ.pop_front()));
    end
  end

  initial begin : watchdog
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 stReady", 64'(stReady), 64'd1);
    chk("R10 memWrValid", 64'(memWrValid), 64'd0);
    chk("R10 saveValid", 64'(saveValid), 64'd0);
    chk("R10 ldHit", 64'(ldHit), 64'd0);
    chk("R10 flags", 64'({fullTrap, commitDone, saveDone}), 64'd0);

    // distinct words and merges; R1 watched by the monitor
    doStore(16'h0010, 32'h11223344, 4'hF);
    doStore(16'h0020, 32'hAABBCCDD, 4'h3);
    doStore(16'h0010, 32'h55000000, 4'h8);  // R4 merge top byte
    doStore(16'h0020, 32'h00EE0000, 4'h4);  // R4 merge byte 2
    probe("R4 merged word", 16'h0010, 1'b1, 32'h55223344, 4'hF);
    probe("R5 load hit", 16'h0020, 1'b1, 32'hAAEECCDD, 4'h7);
    probe("R5 load miss", 16'h0030, 1'b0, '0, '0);
    chk("R1 no write before commit", 64'(memQ.size()), 64'd0);
    drain(1'b0);                              // R2, R3, R7
    probe("R7 busy store ignored", 16'h0777, 1'b0, '0, '0);
    probe("R3 empty after commit", 16'h0010, 1'b0, '0, '0);

    // fill, overflow, merge while full
    doStore(16'h0100, 32'h00000001, 4'hF);
    doStore(16'h0200, 32'h00000002, 4'hF);
    doStore(16'h0300, 32'h00000003, 4'hF);
    doStore(16'h0400, 32'h00000004, 4'hF);
    doStore(16'h0500, 32'h00000005, 4'hF);  // R6 trap
    probe("R6 refused word absent", 16'h0500, 1'b0, '0, '0);
    doStore(16'h0200, 32'h0000BB00, 4'h2);  // R6 merge when full
    probe("R6 merge while full", 16'h0200, 1'b1, 32'h0000BB02, 4'hF);

    // save, then restore in reversed order, then commit
    begin
      logic [AW-1:0] sa[$]; logic [DW-1:0] sd[$]; logic [BW-1:0] sb[$];
      sa = mA; sd = mD; sb = mB;
      drain(1'b1);                             // R8
      probe("R8 empty after save", 16'h0100, 1'b0, '0, '0);
      for (int i = DP - 1; i >= 0; i--) doRestore(sa[i], sd[i], sb[i]);
      probe("R9 restored entry", 16'h0200, 1'b1, 32'h0000BB02, 4'hF);
      probe("R9 store lost to restore", 16'h0EEE, 1'b0, '0, '0);
      drain(1'b0);                             // R9 order follows restore order
    end

    // empty commit: done in the cycle after the request
    drain(1'b0);                               // R3

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule